// File: doc/BRIEF.md
# Per-Character Blink Attribute Controller

This block holds a one-bit blink attribute for each of eight character positions and produces a blank strobe for each position. A bus write with the flash select asserted stores data bit 0 into the flag addressed by the three low address bits. The two upper address bits and data bits 7..1 play no part in that access. A bus read with the flash select asserted returns the addressed flag on data bit 0, with zeros above it.

A free-running divider on the display clock splits each blink period into an "on" half followed by an "off" half. The default period is 28,672 clocks, which gives roughly 2 Hz at the nominal display clock. A position's blank output is high only when three conditions hold together: the global blink enable is set, that position's flag is set, and the divider is in its off half. The global enable is bit 3 of a control word held outside this block. The pixel drive downstream uses the blank outputs to suppress characters. A parameter sets the half-period, so a bench can shorten the period while keeping the equal split.

Top module: `blink_attr_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every flag reads 0 and every blank output is 0.
- R2: A write (flash_sel=1, wr_en=1) stores wdata[0] into the flag selected by addr[2:0]. Value 1 sets the flag, value 0 clears it. The new value is visible from the next clock edge.
- R3: addr[4:3] have no effect on which flag a flash-select access touches.
- R4: wdata[7:1] have no effect on the stored flag.
- R5: A write with flash_sel=0 changes no flag.
- R6: With flash_sel=1 and rd_en=1, rdata[0] equals the flag at addr[2:0] and rdata[7:1] are 0. rdata is all zeros when no flash-select read is active.
- R7: blank[i] is 1 exactly when blink_en=1, flag i is 1 and the blink phase is off.
- R8: The blink period is 2*HALF_CYCLES clocks (default 28,672). The divider counts rising edges since reset release, and the phase is on for counts 0..HALF_CYCLES-1 of each period and off for the rest.
- R9: With blink_en=0 every blank output stays 0, whatever the flags and the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flash_sel | input | 1 | Selects the attribute memory for a bus access |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 5 | Bus address; only bits 2..0 choose a position |
| wdata | input | 8 | Bus write data; only bit 0 is stored |
| rdata | output | 8 | Read-back data, combinational |
| blink_en | input | 1 | Global blink enable (control word bit 3) |
| blank | output | 8 | Per-position blank strobe |

## Verification
The assertions assume that rst_n is held low for at least one rising edge before any check matters. They also assume that wr_en and rd_en are only sampled as a flash-select access when flash_sel is high, and that bus inputs are stable around each rising edge. The bench changes every input on the falling edge only. It releases reset on a falling edge, so the divider's count after reset is a plain count of rising edges. It also pulses wr_en for exactly one cycle per write.

// File: rtl/blink_attr_pkg.sv
package blink_attr_pkg;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } blink_phase_e;

    localparam int unsigned DEF_HALF_CYCLES = 14336;
    localparam int unsigned DEF_NUM_POS     = 8;

endpackage

// File: rtl/blink_divider.sv
module blink_divider
    import blink_attr_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = DEF_HALF_CYCLES
) (
    input  logic         clk,
    input  logic         rst_n,
    output blink_phase_e phase
);

    localparam int unsigned PERIOD = 2 * HALF_CYCLES;
    localparam int unsigned CNT_W  = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(HALF_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = (st_q.cnt >= HALF) ? PH_OFF : PH_ON;

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R8
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> (st_q.cnt == '0));

    // R8
    phase_enter_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == HALF - 1'b1) |=> (phase == PH_OFF));

endmodule

// File: rtl/blink_flag_store.sv
module blink_flag_store #(
    parameter int unsigned NUM_POS = 8,
    parameter int unsigned IDX_W   = $clog2(NUM_POS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_fire,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wbit,
    output logic [NUM_POS-1:0] flags,
    output logic               rbit
);

    typedef struct packed {
        logic [NUM_POS-1:0] flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    for (genvar g = 0; g < NUM_POS; g++) begin : g_pos
        always_comb begin
            if (wr_fire && (idx == IDX_W'(g))) begin
                st_d.flag[g] = wbit;
            end else begin
                st_d.flag[g] = st_q.flag[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;
    assign rbit  = st_q.flag[idx];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (flags[$past(idx)] == $past(wbit)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(flags));

    // R2
    single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(flags ^ $past(flags)) <= 1));

endmodule

// File: rtl/blink_blank_gate.sv
module blink_blank_gate
    import blink_attr_pkg::*;
#(
    parameter int unsigned NUM_POS = 8
) (
    input  logic               blink_en,
    input  blink_phase_e       phase,
    input  logic [NUM_POS-1:0] flags,
    output logic [NUM_POS-1:0] blank
);

    logic off_now;
    assign off_now = blink_en && (phase == PH_OFF);

    for (genvar g = 0; g < NUM_POS; g++) begin : g_gate
        assign blank[g] = off_now & flags[g];
    end

endmodule

// File: rtl/blink_attr_ctrl.sv
module blink_attr_ctrl
    import blink_attr_pkg::*;
#(
    parameter int unsigned NUM_POS     = DEF_NUM_POS,
    parameter int unsigned HALF_CYCLES = DEF_HALF_CYCLES,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flash_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               blink_en,
    output logic [NUM_POS-1:0] blank
);

    localparam int unsigned IDX_W = $clog2(NUM_POS);

    logic               wr_fire;
    logic               rd_fire;
    logic [IDX_W-1:0]   idx;
    logic [NUM_POS-1:0] flags;
    logic               rbit;
    blink_phase_e       phase;

    assign wr_fire = flash_sel && wr_en;
    assign rd_fire = flash_sel && rd_en;
    assign idx     = addr[IDX_W-1:0];

    blink_flag_store #(
        .NUM_POS (NUM_POS),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .idx     (idx),
        .wbit    (wdata[0]),
        .flags   (flags),
        .rbit    (rbit)
    );

    blink_divider #(
        .HALF_CYCLES (HALF_CYCLES)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    blink_blank_gate #(
        .NUM_POS (NUM_POS)
    ) u_gate (
        .blink_en (blink_en),
        .phase    (phase),
        .flags    (flags),
        .blank    (blank)
    );

    always_comb begin
        rdata = '0;
        if (rd_fire) begin
            rdata[0] = rbit;
        end
    end

    // R6
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:1] == '0);

    // R9
    no_blank_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |-> (blank == '0));

    // R7
    blank_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((blank & ~flags) == '0));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

endmodule

// File: tb/blink_attr_ctrl_tb.sv
module blink_attr_ctrl_tb;

    localparam int unsigned HALF   = 4;
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned NPOS   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flash_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       blink_en = 1'b0;
    logic [7:0] blank;

    int total = 0;
    int bad = 0;
    int mcyc = 0;
    int wd = 0;

    always #5 clk = ~clk;

    // independent cycle model: rising edges since reset release
    always @(posedge clk) begin
        if (!rst_n) mcyc <= 0;
        else        mcyc <= mcyc + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    blink_attr_ctrl #(
        .HALF_CYCLES (HALF)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .flash_sel (flash_sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .blink_en  (blink_en),
        .blank     (blank)
    );

    typedef struct packed {
        logic [4:0] a;
        logic [7:0] d;
        logic [7:0] exp_flags;
    } vec_t;

    // R2 basic set/clear, R3 upper address bits ignored, R4 upper data bits ignored
    localparam vec_t VECS [8] = '{
        '{5'b00000, 8'h01, 8'h01},
        '{5'b00111, 8'hFF, 8'h81},
        '{5'b11010, 8'h01, 8'h85},
        '{5'b00111, 8'hFE, 8'h05},
        '{5'b01000, 8'h00, 8'h04},
        '{5'b10011, 8'h03, 8'h0C},
        '{5'b00101, 8'h81, 8'h2C},
        '{5'b00010, 8'h00, 8'h28}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        flash_sel = sel; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        flash_sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic read_all(output logic [7:0] f);
        for (int p = 0; p < NPOS; p++) begin
            @(negedge clk);
            flash_sel = 1'b1; rd_en = 1'b1; addr = 5'(p) | 5'b10000;
            #1;
            f[p] = rdata[0];
            check("R6 upper bits", 32'(rdata[7:1]), 32'h0);
        end
        @(negedge clk);
        flash_sel = 1'b0; rd_en = 1'b0; addr = '0;
    endtask

    task automatic check_blank(input string tag, input logic [7:0] f, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(tag, 32'(blank),
                  32'((blink_en && ((mcyc % PERIOD) >= HALF)) ? f : 8'h00));
        end
    endtask

    initial begin
        logic [7:0] f;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 blank in reset", 32'(blank), 32'h0);
        rst_n = 1'b1;
        read_all(f);
        check("R1 flags after reset", 32'(f), 32'h0);

        // table walk: R2 R3 R4
        foreach (VECS[i]) begin
            bus_write(1'b1, VECS[i].a, VECS[i].d);
            read_all(f);
            check("R2 R3 R4 flags", 32'(f), 32'(VECS[i].exp_flags));
        end

        // R6 no read active -> zero
        @(negedge clk);
        flash_sel = 1'b0; rd_en = 1'b1; addr = 5'd2;
        #1 check("R6 no select read", 32'(rdata), 32'h0);
        rd_en = 1'b0;

        // R5 write without flash select
        bus_write(1'b0, 5'd1, 8'h01);
        bus_write(1'b0, 5'd3, 8'h00);
        read_all(f);
        check("R5 unselected write", 32'(f), 32'h28);

        // R7 / R8 blank follows phase over two periods
        blink_en = 1'b1;
        check_blank("R7 R8 blank pattern", 8'h28, 2 * PERIOD);

        // R9 global enable off
        blink_en = 1'b0;
        check_blank("R9 enable off", 8'h28, PERIOD);

        // R8 reset restarts divider in on half; R1 clears flags
        blink_en = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 blank under reset", 32'(blank), 32'h0);
        rst_n = 1'b1;
        check_blank("R1 blank after reset", 8'h00, 2);
        bus_write(1'b1, 5'd6, 8'h01);
        check_blank("R8 restart phase", 8'h40, 2 * PERIOD);
        read_all(f);
        check("R1 R2 flags after reset", 32'(f), 32'h40);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule